// File: doc/BRIEF.md
# Multi-Polynomial CRC Engine

This block computes CRC checksums behind a small 32-bit register interface. A mode register picks one of three generator polynomials (a 32-bit one and two 16-bit ones). It also sets four conditioning options:

- bit reversal within each incoming byte;
- inversion of each incoming byte;
- bit reversal of the checksum as it is read;
- inversion of the checksum as it is read.

Software writes a seed, then pushes 1, 2 or 4 bytes per data write, then reads the checksum.

Each accepted data write is queued internally and consumed one byte per clock, most significant byte first. While bytes remain, `wr_ready` is low and every write is dropped. The output conditioning is purely combinational on the read path. It never changes the stored CRC state, so reading the raw state always shows the true running remainder.

Register addresses:

| Address | Register | Access |
|---|---|---|
| 0 | mode | read/write, 6 bits, zero-extended on read |
| 1 | seed | writes load the state, reads return the raw state |
| 2 | data | write-only, reads 0 |
| 3 | checksum | read-only |

Top module: `crc_engine`

## Requirements
- R1: After reset the mode register, the raw state and the checksum all read 0, and `wr_ready` is 1.
- R2: Mode bits [1:0] pick the polynomial: `1x` gives 0x04C11DB7 over 32 bits, `01` gives 0x8005 over 16 bits, and `00` gives 0x1021 over 16 bits. Each byte is shifted in MSB first into a non-reflected register.
- R3: When mode bit 2 is set, each data byte has its bit order reversed before it enters the CRC.
- R4: When mode bit 3 is set, each data byte is inverted before it enters the CRC. Reversal is applied first.
- R5: When mode bit 4 is set, the checksum reads bit-reversed. The reversal spans 32 bits in the 32-bit mode and the low 16 bits in the 16-bit modes.
- R6: When mode bit 5 is set, the checksum reads inverted, over the active width.
- R7: In the 16-bit modes, bits [31:16] of the checksum read 0, and each byte step clears bits [31:16] of the state.
- R8: A write to address 1 loads the state from `wdata`. A write to address 0 stores `wdata[5:0]` as the mode and leaves the state unchanged. Address 0 reads back the mode.
- R9: A write to address 2 queues data according to `wstrb`:
  - `0001` queues `wdata[7:0]` as one byte;
  - `0011` queues `wdata[15:0]` as two bytes;
  - `1111` queues `wdata[31:0]` as four bytes;
  - any other strobe pattern is ignored.
  Queued bytes are consumed high byte first, one per clock.
- R10: After a write of N bytes is accepted, `wr_ready` is low for exactly N cycles, and any write made while it is low has no effect.
- R11: The output options and writes to address 3 never alter the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register address for both read and write |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte-lane strobes, used for data writes |
| wr_ready | output | 1 | High when a write will be accepted |
| rdata | output | 32 | Combinational read data for `addr` |

## Verification
Timing of each result:
- A mode or seed write is visible on `rdata` in the same low clock phase that follows the accepting edge.
- A data write of N bytes leaves `wr_ready` low at N consecutive falling edges. The checksum is final at the first falling edge where `wr_ready` is high again.

How the bench keeps to that timing:
- It drives inputs on falling edges and reads `rdata` one time unit after setting `addr`.
- It counts the falling edges that see `wr_ready` low after every data write, and compares that count with the number of bytes written.
- It compares the checksum and the raw state only once `wr_ready` has returned high.

// File: rtl/crc_engine_pkg.sv
package crc_engine_pkg;

    // Register map, decoded by the top module.
    typedef enum logic [1:0] {
        REG_MODE = 2'd0,
        REG_SEED = 2'd1,
        REG_DATA = 2'd2,
        REG_SUM  = 2'd3
    } reg_addr_t;

    // Mode word.  Packed order puts poly_sel at bits [1:0] and out_cmpl at bit 5.
    typedef struct packed {
        logic       out_cmpl;
        logic       out_rev;
        logic       in_cmpl;
        logic       in_rev;
        logic [1:0] poly_sel;
    } crc_mode_t;

    localparam int MODE_W = $bits(crc_mode_t);

endpackage

// File: rtl/crc_in_xform.sv
module crc_in_xform (
    input  logic [7:0] raw,
    input  logic       rev,
    input  logic       cmpl,
    output logic [7:0] cooked
);
    logic [7:0] flipped;

    for (genvar g = 0; g < 8; g++) begin : g_rev
        assign flipped[g] = raw[7-g];
    end

    always_comb begin
        cooked = rev ? flipped : raw;
        if (cmpl) begin
            cooked = ~cooked;
        end
    end
endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
    parameter int               W          = 32,
    parameter logic [W-1:0]     POLY_WIDE  = 32'h04C1_1DB7,
    parameter logic [15:0]      POLY_NAR_A = 16'h8005,
    parameter logic [15:0]      POLY_NAR_B = 16'h1021
) (
    input  logic [W-1:0] state,
    input  logic [7:0]   din,
    input  logic         wide,
    input  logic         nar_sel_a,
    output logic [W-1:0] next
);
    logic [W-1:0] sw;
    logic [15:0]  sn;
    logic [15:0]  pn;
    logic         fbw;
    logic         fbn;

    always_comb begin
        pn = nar_sel_a ? POLY_NAR_A : POLY_NAR_B;
        sw = state;
        sn = state[15:0];
        fbw = 1'b0;
        fbn = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            fbw = sw[W-1] ^ din[i];
            sw  = {sw[W-2:0], 1'b0} ^ ({W{fbw}} & POLY_WIDE);
            fbn = sn[15] ^ din[i];
            sn  = {sn[14:0], 1'b0} ^ ({16{fbn}} & pn);
        end
        next = wide ? sw : W'(sn);
    end
endmodule

// File: rtl/crc_out_xform.sv
module crc_out_xform #(
    parameter int W = 32
) (
    input  logic [W-1:0] state,
    input  logic         wide,
    input  logic         rev,
    input  logic         cmpl,
    output logic [W-1:0] result
);
    logic [W-1:0] rev_w;
    logic [15:0]  rev_n;
    logic [W-1:0] val_w;
    logic [15:0]  val_n;

    for (genvar g = 0; g < W; g++) begin : g_rev_w
        assign rev_w[g] = state[W-1-g];
    end
    for (genvar g = 0; g < 16; g++) begin : g_rev_n
        assign rev_n[g] = state[15-g];
    end

    always_comb begin
        val_w = rev ? rev_w : state;
        val_n = rev ? rev_n : state[15:0];
        if (cmpl) begin
            val_w = ~val_w;
            val_n = ~val_n;
        end
        result = wide ? val_w : W'(val_n);
    end
endmodule

// File: rtl/crc_engine.sv
module crc_engine
    import crc_engine_pkg::*;
#(
    parameter int                   DATA_W     = 32,
    parameter logic [DATA_W-1:0]    POLY_WIDE  = 32'h04C1_1DB7,
    parameter logic [15:0]          POLY_16    = 16'h8005,
    parameter logic [15:0]          POLY_CCITT = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    output logic              wr_ready,
    output logic [DATA_W-1:0] rdata
);
    localparam int NB    = DATA_W / 8;
    localparam int CNT_W = $clog2(NB + 1);

    typedef struct packed {
        crc_mode_t          mode;
        logic [DATA_W-1:0]  state;
        logic [DATA_W-1:0]  pend;
        logic [CNT_W-1:0]   cnt;
    } regs_t;

    regs_t st_d;
    regs_t st_q;

    crc_mode_t         mode_q;
    logic [DATA_W-1:0] state_q;
    logic [7:0]        byte_cooked;
    logic [DATA_W-1:0] step_next;
    logic [DATA_W-1:0] sum_view;
    logic              wide;
    logic              accept;

    assign mode_q  = st_q.mode;
    assign state_q = st_q.state;
    assign wide    = st_q.mode.poly_sel[1];

    crc_in_xform u_in (
        .raw    (st_q.pend[DATA_W-1 -: 8]),
        .rev    (st_q.mode.in_rev),
        .cmpl   (st_q.mode.in_cmpl),
        .cooked (byte_cooked)
    );

    crc_byte_step #(
        .W          (DATA_W),
        .POLY_WIDE  (POLY_WIDE),
        .POLY_NAR_A (POLY_16),
        .POLY_NAR_B (POLY_CCITT)
    ) u_step (
        .state     (st_q.state),
        .din       (byte_cooked),
        .wide      (wide),
        .nar_sel_a (st_q.mode.poly_sel[0]),
        .next      (step_next)
    );

    crc_out_xform #(.W(DATA_W)) u_out (
        .state  (st_q.state),
        .wide   (wide),
        .rev    (st_q.mode.out_rev),
        .cmpl   (st_q.mode.out_cmpl),
        .result (sum_view)
    );

    always_comb begin
        st_d   = st_q;
        accept = wr_en && (st_q.cnt == '0);

        if (st_q.cnt != '0) begin
            st_d.state = step_next;
            st_d.pend  = st_q.pend << 8;
            st_d.cnt   = st_q.cnt - 1'b1;
        end

        if (accept) begin
            case (reg_addr_t'(addr))
                REG_MODE: st_d.mode  = crc_mode_t'(wdata[MODE_W-1:0]);
                REG_SEED: st_d.state = wdata;
                REG_DATA: begin
                    for (int k = 1; k <= NB; k = k * 2) begin
                        if (wstrb == NB'((1 << k) - 1)) begin
                            st_d.pend = wdata << (DATA_W - 8 * k);
                            st_d.cnt  = CNT_W'(k);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ready = (st_q.cnt == '0);

    always_comb begin
        case (reg_addr_t'(addr))
            REG_MODE: rdata = DATA_W'(st_q.mode);
            REG_SEED: rdata = st_q.state;
            REG_SUM:  rdata = sum_view;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                wr_ready,
    input logic [1:0]          addr,
    input logic [DATA_W-1:0]   wdata,
    input logic [DATA_W/8-1:0] wstrb,
    input logic [DATA_W-1:0]   rdata,
    input logic [5:0]          mode,
    input logic [DATA_W-1:0]   state
);
    localparam int NB = DATA_W / 8;

    // R8
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ready && addr == 2'd1) |=> (state == $past(wdata)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && !(wr_en && addr == 2'd1)) |=> $stable(state));

    // R10
    busy_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ready && addr == 2'd2 && wstrb == '1) |=> !wr_ready);

    // R9
    bad_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ready && addr == 2'd2 && wstrb != NB'(1)
         && wstrb != NB'(3) && wstrb != '1) |=> wr_ready);

    // R7
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[1] && addr == 2'd3) |-> (rdata[DATA_W-1:16] == '0));
endmodule

bind crc_engine crc_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_ready (wr_ready),
    .addr     (addr),
    .wdata    (wdata),
    .wstrb    (wstrb),
    .rdata    (rdata),
    .mode     (mode_q),
    .state    (state_q)
);

// File: tb/crc_engine_tb.sv
module crc_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        wr_ready;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] exp_state;
    logic [5:0]  exp_mode;

    always #4 clk = ~clk;

    crc_engine u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .wstrb(wstrb), .wr_ready(wr_ready), .rdata(rdata)
    );

    function automatic logic [31:0] ref_byte(input logic [31:0] s, input logic [7:0] b,
                                             input logic [5:0] m);
        logic [7:0]  d;
        logic [15:0] s16;
        logic        fb;
        d = b;
        if (m[2]) for (int i = 0; i < 8; i++) d[i] = b[7-i];
        if (m[3]) d = ~d;
        if (m[1]) begin
            for (int i = 7; i >= 0; i--) begin
                fb = s[31] ^ d[i];
                s  = {s[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
            end
            return s;
        end
        s16 = s[15:0];
        for (int i = 7; i >= 0; i--) begin
            fb  = s16[15] ^ d[i];
            s16 = {s16[14:0], 1'b0} ^ (fb ? (m[0] ? 16'h8005 : 16'h1021) : 16'h0);
        end
        return {16'h0, s16};
    endfunction

    function automatic logic [31:0] ref_out(input logic [31:0] s, input logic [5:0] m);
        logic [31:0] v;
        logic [15:0] v16;
        if (m[1]) begin
            v = s;
            if (m[4]) for (int i = 0; i < 32; i++) v[i] = s[31-i];
            if (m[5]) v = ~v;
            return v;
        end
        v16 = s[15:0];
        if (m[4]) for (int i = 0; i < 16; i++) v16[i] = s[15-i];
        if (m[5]) v16 = ~v16;
        return {16'h0, v16};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All tasks are entered and left at a falling edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] s);
        wr_en = 1'b1; addr = a; wdata = d; wstrb = s;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wstrb = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic set_mode(input logic [5:0] m);
        wr(2'd0, {26'h0, m}, 4'hF);
        exp_mode = m;
    endtask

    task automatic set_seed(input logic [31:0] s);
        wr(2'd1, s, 4'hF);
        exp_state = s;
    endtask

    task automatic push(input logic [31:0] d, input int nbytes);
        int busy;
        logic [3:0] s;
        s = (nbytes == 1) ? 4'b0001 : (nbytes == 2) ? 4'b0011 : 4'b1111;
        wr(2'd2, d, s);
        for (int i = nbytes - 1; i >= 0; i--)
            exp_state = ref_byte(exp_state, d[8*i +: 8], exp_mode);
        busy = 0;
        while (!wr_ready && busy < 10) begin
            busy++;
            @(negedge clk);
        end
        check("R10 busy cycles", busy, nbytes);
    endtask

    task automatic check_sum(input string req);
        logic [31:0] v;
        rd(2'd3, v);
        check(req, v, ref_out(exp_state, exp_mode));
        rd(2'd1, v);
        check("R11 raw state", v, exp_state);
    endtask

    task automatic push_digits(input int width);
        logic [71:0] msg;
        msg = "123456789";
        if (width == 4) begin
            push(msg[71:40], 4); push(msg[39:8], 4); push({24'h0, msg[7:0]}, 1);
        end else if (width == 2) begin
            for (int i = 0; i < 4; i++) push({16'h0, msg[71-16*i -: 16]}, 2);
            push({24'h0, msg[7:0]}, 1);
        end else begin
            for (int i = 0; i < 9; i++) push({24'h0, msg[71-8*i -: 8]}, 1);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] held;
        void'($urandom(32'd1729));
        exp_state = '0; exp_mode = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); check("R1 mode reset", v, 32'h0);
        rd(2'd1, v); check("R1 state reset", v, 32'h0);
        rd(2'd3, v); check("R1 sum reset", v, 32'h0);
        check("R1 ready reset", {31'h0, wr_ready}, 32'h1);

        // R2 CCITT, known check value
        set_seed(32'h0000FFFF);
        push_digits(1);
        rd(2'd3, v); check("R2 ccitt check value", v, 32'h000029B1);

        // R2 R3 R5 R6 CRC-32 reflected, known check value
        set_mode(6'b110110);
        set_seed(32'hFFFFFFFF);
        push_digits(1);
        rd(2'd3, v); check("R2 R3 R5 R6 crc32 check value", v, 32'hCBF43926);

        // R9 word writes give the same result
        set_seed(32'hFFFFFFFF);
        push_digits(4);
        rd(2'd3, v); check("R9 crc32 word writes", v, 32'hCBF43926);

        // R2 R7 CRC-16 reflected, known check value
        set_mode(6'b010101);
        set_seed(32'h0);
        push_digits(2);
        rd(2'd3, v); check("R2 R7 crc16 check value", v, 32'h0000BB3D);

        // R4 input complement against model
        set_mode(6'b001010);
        set_seed(32'h12345678);
        push(32'hA5C3_0F81, 4);
        check_sum("R4 input complement");

        // R7 16-bit mode clears state upper half
        set_mode(6'b000001);
        set_seed(32'hDEAD_BEEF);
        push(32'h0000_0042, 1);
        rd(2'd1, v); check("R7 upper state cleared", v & 32'hFFFF0000, 32'h0);

        // R8 mode write keeps state; R5 R6 output options change view only
        held = exp_state;
        set_mode(6'b110000);
        rd(2'd1, v); check("R8 mode write keeps state", v, held);
        rd(2'd0, v); check("R8 mode readback", v, 32'h30);
        check_sum("R5 R6 narrow output");

        // R9 invalid strobe ignored
        wr(2'd2, 32'hFFFF_FFFF, 4'b0101);
        check("R9 bad strobe ready", {31'h0, wr_ready}, 32'h1);
        rd(2'd1, v); check("R9 bad strobe state", v, held);

        // R11 write to checksum address ignored
        wr(2'd3, 32'h5555_AAAA, 4'hF);
        rd(2'd1, v); check("R11 sum write ignored", v, held);

        // R10 writes while busy dropped
        set_mode(6'b000010);
        set_seed(32'h0BAD_F00D);
        wr(2'd2, 32'h0102_0304, 4'hF);
        wr(2'd1, 32'hFFFF_FFFF, 4'hF);
        wr(2'd0, 32'h0000_0000, 4'hF);
        for (int i = 3; i >= 0; i--)
            exp_state = ref_byte(exp_state, 8'(4 - i), exp_mode);
        repeat (4) @(negedge clk);
        check_sum("R10 writes while busy dropped");
        rd(2'd0, v); check("R10 mode unchanged", v, 32'h2);

        // Random traffic
        for (int it = 0; it < 60; it++) begin
            int nw;
            set_mode(6'($urandom));
            set_seed($urandom);
            nw = 1 + ($urandom % 5);
            for (int j = 0; j < nw; j++) begin
                int sz;
                sz = 1 << ($urandom % 3);
                push($urandom & ((sz == 4) ? 32'hFFFFFFFF : ((32'h1 << (8 * sz)) - 1)), sz);
            end
            check_sum("R2 R3 R4 R5 R6 random");
            set_mode(6'($urandom));
            check_sum("R8 R11 random mode switch");
            rd(2'd0, v); check("R8 random mode readback", v, {26'h0, exp_mode});
        end

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule